// File: doc/BRIEF.md
# Dual Fractional Baud Tick Generator

This block derives two sample-clock enables from a single reference clock: a base tick for an infrared serial link and a 16x oversampling bit tick for a UART. Each path has an integer divisor and a 4-bit correction in sixteenths of a clock. A 4-bit phase accumulator adds the correction once per period. When it overflows, that period is one clock longer. The long-run average period therefore equals the integer plus the fraction.

The infrared path divides by its stored integer plus one. It aims at a base tick near 1.8432 MHz. The UART path counts in whole groups of 16 reference clocks, so its period is 16 times (stored count plus one), plus the dithered correction. Both settings are written through one small write port. A new setting takes effect at the next period boundary, so the period already in progress is never cut short. A stored infrared integer of zero is illegal: the block raises a configuration error and holds the infrared tick low until a legal value is written.

Top module: `fracbaud_gen`

## Requirements
- R1: After reset both ticks and `cfg_err` are low. The reset setting is an infrared integer field of 1 (divisor 2) and a UART count of 0 (period 16), with both fractions at 0.
- R2: A write happens when `wr_en` is high at a clock edge. `wr_sel` picks the target: 0 sets the infrared fraction from `wr_data[7:4]`, 1 sets the infrared integer field from `wr_data[3:0]` (divisor = field + 1), 2 sets the UART fraction from `wr_data[7:4]`, and 3 sets the UART count from `wr_data[UCW-1:0]`.
- R3: With infrared field n (n ≥ 1) and fraction f, each interval between infrared ticks is n+1 or n+2 clocks. Any 16 consecutive intervals total 16·(n+1)+f clocks.
- R4: With UART count c and fraction f, each interval between UART ticks is 16·(c+1) or 16·(c+1)+1 clocks. Any 16 consecutive intervals total 256·(c+1)+f clocks.
- R5: Each tick is high for exactly one clock cycle.
- R6: While the infrared integer field is zero, `cfg_err` is high and no infrared tick is produced beyond one already in flight. Writing a nonzero field clears `cfg_err` and restarts the ticks.
- R7: A write made partway through a period leaves that period's length unchanged. The new setting governs from the following period on.
- R8: Both ticks are high in the cycle after the first clock edge at which reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 2 | Setting select (see R2) |
| wr_data | input | 16 | Setting write data |
| irda_tick | output | 1 | Infrared base tick, one cycle wide |
| uart_tick | output | 1 | UART 16x tick, one cycle wide |
| cfg_err | output | 1 | Infrared integer field is zero |

## Verification
The bench measures 16 consecutive intervals for each configured path. It checks the exact total as well as the shortest and longest interval. A design that adds the carry to every period, or loses the accumulator between periods, gets the total wrong, and a design that places the stretch anywhere but one clock fails the per-interval bounds. A setting is rewritten partway through a long period: a design that reloads the counter at the moment of the write shortens that interval and is caught. The zero-divisor case is checked for silence on the infrared tick and for recovery afterwards. The first tick after reset is checked on its exact cycle.

// File: rtl/fracbaud_gen.sv
module fracbaud_gen #(
  parameter int UCW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic        irda_tick,
  output logic        uart_tick,
  output logic        cfg_err
);
  localparam int FW   = 4;
  localparam int IW   = 4;
  localparam int IRCW = IW + 1;
  localparam int UCCW = UCW + FW + 1;

  logic [FW-1:0]   ir_frac, u_frac, ir_acc, u_acc;
  logic [IW-1:0]   ir_int;
  logic [UCW-1:0]  u_div;
  logic [IRCW-1:0] ir_cnt;
  logic [UCCW-1:0] u_cnt;

  wire            ir_end = (ir_cnt == '0);
  wire            u_end  = (u_cnt == '0);
  wire [FW:0]     ir_sum = {1'b0, ir_acc} + {1'b0, ir_frac};
  wire [FW:0]     u_sum  = {1'b0, u_acc} + {1'b0, u_frac};
  wire [IRCW-1:0] ir_load = IRCW'(ir_int) + IRCW'(ir_sum[FW]);
  wire [UCCW-1:0] u_load  = UCCW'({u_div, 4'hF}) + UCCW'(u_sum[FW]);

  assign cfg_err = (ir_int == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ir_frac <= '0;
      ir_int  <= IW'(1);
      u_frac  <= '0;
      u_div   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: ir_frac <= wr_data[7:4];
        2'd1: ir_int  <= wr_data[IW-1:0];
        2'd2: u_frac  <= wr_data[7:4];
        default: u_div <= wr_data[UCW-1:0];
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ir_cnt    <= '0;
      ir_acc    <= '0;
      irda_tick <= 1'b0;
    end else begin
      irda_tick <= ir_end && (ir_int != '0);
      if (ir_end) begin
        ir_cnt <= ir_load;
        ir_acc <= ir_sum[FW-1:0];
      end else begin
        ir_cnt <= ir_cnt - 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      u_cnt     <= '0;
      u_acc     <= '0;
      uart_tick <= 1'b0;
    end else begin
      uart_tick <= u_end;
      if (u_end) begin
        u_cnt <= u_load;
        u_acc <= u_sum[FW-1:0];
      end else begin
        u_cnt <= u_cnt - 1'b1;
      end
    end

  assert_irda_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irda_tick |=> !irda_tick);
  assert_uart_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    uart_tick |=> !uart_tick);
  assert_err_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !irda_tick);
  assert_irda_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irda_tick |-> ir_cnt != '0);
  assert_irda_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ir_cnt <= IRCW'(16));
  assert_uart_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uart_tick |-> u_cnt >= UCCW'(15));
endmodule

// File: tb/tb_fracbaud_gen.sv
module tb_fracbaud_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {path(1=uart), value[11:0], frac[3:0]}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 12'd1,  4'd0},
    {1'b0, 12'd7,  4'd5},
    {1'b0, 12'd15, 4'd15},
    {1'b0, 12'd3,  4'd8},
    {1'b1, 12'd0,  4'd0},
    {1'b1, 12'd0,  4'd15},
    {1'b1, 12'd2,  4'd3},
    {1'b1, 12'd1,  4'd9}
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic irda_tick, uart_tick, cfg_err;
  int errors = 0, checks = 0;
  int cyc = 0;

  fracbaud_gen dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
                    .wr_data(wr_data), .irda_tick(irda_tick), .uart_tick(uart_tick),
                    .cfg_err(cfg_err));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  int dbl = 0;
  task automatic next_tick(input bit p, output int n);
    logic prev;
    n = 0;
    prev = p ? uart_tick : irda_tick;
    do begin
      @(negedge clk);
      n++;
      if (prev && (p ? uart_tick : irda_tick)) dbl++;
      prev = p ? uart_tick : irda_tick;
    end while (!(p ? uart_tick : irda_tick) && n < 100000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n, sum, mn, mx, fi, fu;
    repeat (3) @(negedge clk);
    check("R1 irda_tick in reset", irda_tick, 0);
    check("R1 uart_tick in reset", uart_tick, 0);
    check("R1 cfg_err in reset", cfg_err, 0);
    rst_n = 1;
    @(negedge clk);
    check("R8 first irda tick", irda_tick, 1);
    check("R8 first uart tick", uart_tick, 1);
    fi = 0; fu = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (irda_tick && fi == 0) fi = i;
      if (uart_tick && fu == 0) fu = i;
    end
    check("R1 default irda period", fi, 2);
    check("R1 default uart period", fu, 16);

    // R2 R3 R4: table of settings
    for (int v = 0; v < NV; v++) begin
      bit p;
      int val, fr, base;
      p = VEC[v][16]; val = int'(VEC[v][15:4]); fr = int'(VEC[v][3:0]);
      if (!p) begin
        wr(2'd0, 16'(fr << 4)); wr(2'd1, 16'(val));
        base = val + 1;
      end else begin
        wr(2'd2, 16'(fr << 4)); wr(2'd3, 16'(val));
        base = 16 * (val + 1);
      end
      next_tick(p, n); next_tick(p, n);
      sum = 0; mn = 1 << 30; mx = 0; dbl = 0;
      for (int k = 0; k < 16; k++) begin
        next_tick(p, n);
        sum += n;
        if (n < mn) mn = n;
        if (n > mx) mx = n;
      end
      check(p ? "R4 uart 16-interval total" : "R3 irda 16-interval total", sum, 16 * base + fr);
      check(p ? "R4 uart shortest" : "R3 irda shortest", mn, (fr == 0) ? base : base);
      check(p ? "R4 uart longest" : "R3 irda longest", mx, (fr == 0) ? base : base + 1);
      check("R5 single-cycle tick", dbl, 0);
    end

    // R7: mid-period write keeps current period
    wr(2'd0, 16'h0000); wr(2'd1, 16'd15);
    next_tick(0, n); next_tick(0, n);
    repeat (3) @(negedge clk);
    wr(2'd1, 16'd1);
    next_tick(0, n);
    check("R7 interrupted period length", n + 5, 16);
    next_tick(0, n);
    check("R7 new period after boundary", n, 2);

    // R6: zero integer field
    wr(2'd1, 16'd0);
    check("R6 cfg_err set", cfg_err, 1);
    repeat (3) @(negedge clk);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irda_tick) n++;
    end
    check("R6 no irda ticks while illegal", n, 0);
    wr(2'd1, 16'd4);
    check("R6 cfg_err cleared", cfg_err, 0);
    next_tick(0, n);
    check("R6 ticks resume promptly", (n <= 3) ? 1 : 0, 1);
    next_tick(0, n);
    check("R6 R2 period after recovery", n, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule